// File: doc/BRIEF.md
# Interrupt Redirection Controller

The block routes a set of external interrupt lines to interrupt messages. Each line owns a redirection entry that holds the vector, delivery mode, destination mode, destination, input polarity, trigger type and mask. A line can be edge-sensitive, where each inactive-to-active transition yields one message. It can also be level-sensitive, where the line keeps requesting while it is active until one delivery has been accepted. After that acceptance it stays silent until software signals end-of-interrupt for that entry's vector. Only the vector, delivery mode, destination mode and destination travel in the message. Choosing a core among the destination candidates is left to the receiver.

Software reaches every register through two 32-bit locations of a plain register port. Offset 0x00 holds an index. Offset 0x10 is a window onto the internal register that the index names. Index 0 holds the controller ID. Index 1 is a read-only version word. Each entry takes two indices, starting at 0x10, with the low word at even indices and the high word at odd ones. Reads have no side effects and return combinationally.

Messages leave through a valid/ready port. Once `msg_valid` is high it stays high, and the payload stays unchanged, until a cycle with `msg_ready` high. The payload is captured from the entry at the moment the message is staged. A held message therefore does not change if software rewrites the entry while it waits. A receiver that holds `msg_ready` low stalls all further deliveries. Requests raised in the meantime are kept: an edge as a latched flag, a level as the live input.

Top module: `irq_router`

## Requirements
- R1: After reset, every entry's low word reads 0x0001_0000, which is masked with all other fields zero. Every high word reads 0. The ID word reads 0. The version word reads VERSION in bits 7:0 and NUM_LINES-1 in bits 23:16. The index register reads 0 and `msg_valid` is low.
- R2: A write at offset 0x00 sets the index register, and its bits 7:0 read back at offset 0x00. Window accesses at offset 0x10 act on the indexed register. Any other offset reads 0, and writes there change nothing. Indices other than 0, 1 and 0x10 through 0x10+2*NUM_LINES-1 read 0, and writes to them have no effect.
- R3: Low-word layout: vector in 7:0, delivery mode in 10:8, destination mode in 11 (1 = logical), delivery status in 12, polarity in 13 (1 = active low), remote IRR in 14, trigger mode in 15 (1 = level) and mask in 16 (1 = masked). Bits 12 and 14 ignore writes. The high word holds the destination in 31:24. The ID is in bits 27:24 of index 0. The version word ignores writes. All other bits read 0.
- R4: Polarity bit 13 set makes a low input the active state, so edge detection and level requests both follow the inverted input.
- R5: An unmasked edge entry produces exactly one message per inactive-to-active transition. An input that is held active produces no further message.
- R6: An unmasked level entry requests while its input is active and its remote IRR is clear. Acceptance of its message sets remote IRR (bit 14). While remote IRR is set, no message is sent. An end-of-interrupt with a non-matching vector leaves remote IRR set.
- R7: An end-of-interrupt pulse clears remote IRR on every level entry whose vector equals `eoi_vector`. Entries with other vectors are left alone. A still-active input then requests again.
- R8: When several entries request at once, messages go out lowest entry number first, one per accepted handshake.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and the payload stay unchanged, including across rewrites of the entry. `msg_valid` falls only after an accepting cycle. The payload carries the entry's vector, delivery mode, destination mode and destination.
- R10: Delivery status (bit 12) reads 1 while the entry has a request or a staged message that has not yet been accepted. It reads 0 once the message is accepted.
- R11: A masked entry sends nothing. An edge that arrives while the entry is masked is discarded and is not delivered on a later unmask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | External interrupt lines, synchronous to clk |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | ADDR_W | Byte offset: 0x00 index, 0x10 window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| msg_valid | output | 1 | Interrupt message is offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_dest | output | 8 | Message destination or core bitmask |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector being acknowledged |

## Verification
A stuck or missed edge latch shows on the next message: a duplicate message appears, or the expected one never arrives, within two cycles of the input change. A wrong remote IRR flag shows at once when bit 14 of the entry is read. It also shows as a level line that stays silent after a matching end-of-interrupt, or one that fires again before it. Errors in the priority order or the staging register show as out-of-order vectors, or as a payload that moves while ready is low. Readback of written and read-only bits exposes field decoding errors on the very next window read.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int VEC_W  = 8;
  localparam int DM_W   = 3;
  localparam int DEST_W = 8;
  localparam int ID_W   = 4;

  localparam int LO_DMODE = 8;
  localparam int LO_LOGIC = 11;
  localparam int LO_DSTAT = 12;
  localparam int LO_POL   = 13;
  localparam int LO_RIRR  = 14;
  localparam int LO_TRIG  = 15;
  localparam int LO_MASK  = 16;
  localparam int HI_DEST  = 24;
  localparam int ID_LSB   = 24;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              level;
    logic              pol_low;
    logic              logical;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vector;
  } entry_cfg_t;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DM_W-1:0]   dmode;
    logic              logical;
    logic [DEST_W-1:0] dest;
  } irq_msg_t;

  localparam entry_cfg_t CFG_RESET = '{dest: '0, mask: 1'b1, level: 1'b0,
                                       pol_low: 1'b0, logical: 1'b0,
                                       dmode: '0, vector: '0};

  function automatic logic [31:0] low_word(entry_cfg_t c, logic dstat, logic rirr);
    logic [31:0] w;
    w = '0;
    w[VEC_W-1:0]            = c.vector;
    w[LO_DMODE +: DM_W]     = c.dmode;
    w[LO_LOGIC]             = c.logical;
    w[LO_DSTAT]             = dstat;
    w[LO_POL]               = c.pol_low;
    w[LO_RIRR]              = rirr;
    w[LO_TRIG]              = c.level;
    w[LO_MASK]              = c.mask;
    return w;
  endfunction

  function automatic logic [31:0] high_word(entry_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[HI_DEST +: DEST_W] = c.dest;
    return w;
  endfunction

endpackage

// File: rtl/irq_line.sv
module irq_line
  import irq_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_in,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  entry_cfg_t       wr_cfg,
  input  logic             accept,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output entry_cfg_t       cfg,
  output logic             req,
  output logic             rirr
);

  logic active;
  logic prev_active;
  logic edge_lat;
  logic rise;

  assign active = irq_in ^ cfg.pol_low;
  assign rise   = active & ~prev_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else begin
      if (wr_lo) begin
        cfg.vector  <= wr_cfg.vector;
        cfg.dmode   <= wr_cfg.dmode;
        cfg.logical <= wr_cfg.logical;
        cfg.pol_low <= wr_cfg.pol_low;
        cfg.level   <= wr_cfg.level;
        cfg.mask    <= wr_cfg.mask;
      end
      if (wr_hi) cfg.dest <= wr_cfg.dest;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_active <= 1'b0;
      edge_lat    <= 1'b0;
      rirr        <= 1'b0;
    end else begin
      prev_active <= active;
      if (rise && !cfg.level && !cfg.mask) edge_lat <= 1'b1;
      else if (accept)                     edge_lat <= 1'b0;
      if (accept && cfg.level)
        rirr <= 1'b1;
      else if (eoi_valid && cfg.level && (eoi_vector == cfg.vector))
        rirr <= 1'b0;
    end
  end

  assign req = !cfg.mask && (cfg.level ? (active && !rirr) : edge_lat);

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 24,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int          NUM_LINES = 24,
  parameter logic [7:0]  VERSION   = 8'h20,
  parameter int          ADDR_W    = 5,
  parameter int          SEL_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [VEC_W-1:0]     msg_vector,
  output logic [DM_W-1:0]      msg_dmode,
  output logic                 msg_logical,
  output logic [DEST_W-1:0]    msg_dest,
  input  logic                 eoi_valid,
  input  logic [VEC_W-1:0]     eoi_vector
);

  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int TBL_BASE = 16;
  localparam int TBL_END  = TBL_BASE + 2 * NUM_LINES;
  localparam logic [ADDR_W-1:0] OFS_SEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_WIN = ADDR_W'(16);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};

  logic [SEL_W-1:0] sel;
  logic [ID_W-1:0]  ctl_id;
  logic             win_we;
  logic             sel_in_tbl;
  int               ent_int;
  entry_cfg_t       wr_cfg;
  logic             unused_wbits;

  entry_cfg_t           cfg   [NUM_LINES];
  logic [31:0]          lo_w  [NUM_LINES];
  logic [31:0]          hi_w  [NUM_LINES];
  logic [NUM_LINES-1:0] req;
  logic [NUM_LINES-1:0] rirr;
  logic [NUM_LINES-1:0] held;
  logic [NUM_LINES-1:0] acc;

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] held_idx;
  irq_msg_t         stage;

  // Register port decode
  assign win_we     = reg_we && (reg_addr == OFS_WIN);
  assign sel_in_tbl = (int'(sel) >= TBL_BASE) && (int'(sel) < TBL_END);
  assign ent_int    = (int'(sel) - TBL_BASE) / 2;

  assign wr_cfg.vector  = reg_wdata[VEC_W-1:0];
  assign wr_cfg.dmode   = reg_wdata[LO_DMODE +: DM_W];
  assign wr_cfg.logical = reg_wdata[LO_LOGIC];
  assign wr_cfg.pol_low = reg_wdata[LO_POL];
  assign wr_cfg.level   = reg_wdata[LO_TRIG];
  assign wr_cfg.mask    = reg_wdata[LO_MASK];
  assign wr_cfg.dest    = reg_wdata[HI_DEST +: DEST_W];
  assign unused_wbits   = ^{reg_wdata[23:17], reg_wdata[LO_RIRR], reg_wdata[LO_DSTAT]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel    <= '0;
      ctl_id <= '0;
    end else begin
      if (reg_we && (reg_addr == OFS_SEL)) sel <= reg_wdata[SEL_W-1:0];
      if (win_we && (sel == SEL_W'(0)))    ctl_id <= reg_wdata[ID_LSB +: ID_W];
    end
  end

  // Per-line entries
  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
      logic wr_lo_i;
      logic wr_hi_i;
      assign wr_lo_i  = win_we && sel_in_tbl && (ent_int == gi) && !sel[0];
      assign wr_hi_i  = win_we && sel_in_tbl && (ent_int == gi) &&  sel[0];
      assign held[gi] = msg_valid && (held_idx == IDX_W'(gi));
      assign acc[gi]  = held[gi] && msg_ready;

      irq_line u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in[gi]),
        .wr_lo      (wr_lo_i),
        .wr_hi      (wr_hi_i),
        .wr_cfg     (wr_cfg),
        .accept     (acc[gi]),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .cfg        (cfg[gi]),
        .req        (req[gi]),
        .rirr       (rirr[gi])
      );

      assign lo_w[gi] = low_word(cfg[gi], req[gi] | held[gi], rirr[gi]);
      assign hi_w[gi] = high_word(cfg[gi]);
    end
  endgenerate

  // Lowest-numbered request wins; the staged entry is excluded
  irq_pick #(.N(NUM_LINES)) u_pick (
    .req (req & ~held),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      held_idx  <= '0;
      stage     <= '0;
    end else if (!msg_valid || msg_ready) begin
      msg_valid <= pick_any;
      if (pick_any) begin
        held_idx <= pick_idx;
        for (int i = 0; i < NUM_LINES; i++) begin
          if (pick_idx == IDX_W'(i)) begin
            stage.vector  <= cfg[i].vector;
            stage.dmode   <= cfg[i].dmode;
            stage.logical <= cfg[i].logical;
            stage.dest    <= cfg[i].dest;
          end
        end
      end
    end
  end

  assign msg_vector  = stage.vector;
  assign msg_dmode   = stage.dmode;
  assign msg_logical = stage.logical;
  assign msg_dest    = stage.dest;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_SEL) begin
      reg_rdata = 32'(sel);
    end else if (reg_addr == OFS_WIN) begin
      if (sel == SEL_W'(0)) begin
        reg_rdata[ID_LSB +: ID_W] = ctl_id;
      end else if (sel == SEL_W'(1)) begin
        reg_rdata = VER_WORD;
      end else if (sel_in_tbl) begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (ent_int == i) reg_rdata = sel[0] ? hi_w[i] : lo_w[i];
        end
      end
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int         NUM_LINES = 24,
  parameter logic [7:0] VERSION   = 8'h20,
  parameter int         ADDR_W    = 5,
  parameter int         SEL_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [SEL_W-1:0]  sel,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_dmode,
  input logic              msg_logical,
  input logic [7:0]        msg_dest
);

  localparam int TBL_BASE = 16;
  localparam int TBL_END  = TBL_BASE + 2 * NUM_LINES;
  localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};

  logic win_rd;
  logic tbl_rd;
  assign win_rd = (reg_addr == ADDR_W'(16));
  assign tbl_rd = win_rd && (int'(sel) >= TBL_BASE) && (int'(sel) < TBL_END);

  // R9: offered message holds until accepted
  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable({msg_vector, msg_dmode, msg_logical, msg_dest})));

  // R9: valid only drops after an accepting cycle
  assert_drop_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_valid) |-> $past(msg_ready));

  // R1: version word contents
  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && (sel == SEL_W'(1))) |-> (reg_rdata == VER_EXP));

  // R3: reserved bits of low and high entry words read zero
  assert_lo_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd && !sel[0]) |-> (reg_rdata[31:17] == 15'd0));

  assert_hi_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd && sel[0]) |-> (reg_rdata[23:0] == 24'd0));

  // R3: ID word only uses bits 27:24
  assert_id_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && (sel == SEL_W'(0))) |-> ((reg_rdata & 32'hF0FF_FFFF) == 32'd0));

  // R2: undefined offsets read zero
  assert_undef_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr != ADDR_W'(0)) && !win_rd) |-> (reg_rdata == 32'd0));

endmodule

bind irq_router irq_router_chk #(
  .NUM_LINES (NUM_LINES),
  .VERSION   (VERSION),
  .ADDR_W    (ADDR_W),
  .SEL_W     (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .sel         (sel),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_vector  (msg_vector),
  .msg_dmode   (msg_dmode),
  .msg_logical (msg_logical),
  .msg_dest    (msg_dest)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;

  localparam int N = 8;
  localparam logic [7:0] VER = 8'h20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_in;
  logic         reg_we;
  logic [4:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         msg_valid;
  logic         msg_ready;
  logic [7:0]   msg_vector;
  logic [2:0]   msg_dmode;
  logic         msg_logical;
  logic [7:0]   msg_dest;
  logic         eoi_valid;
  logic [7:0]   eoi_vector;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  irq_router #(.NUM_LINES(N), .VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dmode(msg_dmode), .msg_logical(msg_logical), .msg_dest(msg_dest),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [31:0] lo_val(input logic [7:0] vec, input logic [2:0] dm,
                                         input logic lg, input logic pol,
                                         input logic lvl, input logic msk);
    return {15'd0, msk, lvl, 1'b0, pol, 1'b0, lg, dm, vec};
  endfunction

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
    reg_write(5'h00, {24'd0, idx});
    reg_write(5'h10, d);
  endtask

  task automatic win_read(input logic [7:0] idx, output logic [31:0] v);
    reg_write(5'h00, {24'd0, idx});
    reg_read(5'h10, v);
  endtask

  function automatic logic [7:0] lo_idx(input int i);
    return 8'(16 + 2 * i);
  endfunction

  task automatic accept();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic [7:0] vec, input logic [2:0] dm,
                            input logic lg, input logic [7:0] dst);
    for (int k = 0; k < 30; k++) begin
      if (msg_valid) break;
      @(negedge clk);
    end
    check({tag, " valid"}, {31'd0, msg_valid}, 32'd1);
    check({tag, " vector"}, {24'd0, msg_vector}, {24'd0, vec});
    check({tag, " fields"}, {20'd0, msg_dmode, msg_logical, msg_dest}, {20'd0, dm, lg, dst});
    accept();
  endtask

  task automatic quiet(input string tag, input int cycles);
    bit seen = 0;
    for (int k = 0; k < cycles; k++) begin
      if (msg_valid) seen = 1;
      @(negedge clk);
    end
    check(tag, {31'd0, seen}, 32'd0);
  endtask

  task automatic eoi(input logic [7:0] vec);
    eoi_valid = 1'b1; eoi_vector = vec;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    msg_ready = 1'b0; eoi_valid = 1'b0; eoi_vector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_read(5'h00, v);
    check("R1 index reg", v, 32'd0);
    check("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
    win_read(8'd0, v);
    check("R1 id", v, 32'd0);
    win_read(8'd1, v);
    check("R1 version", v, {8'd0, 8'(N - 1), 8'd0, VER});
    for (int i = 0; i < N; i++) begin
      win_read(lo_idx(i), v);
      check($sformatf("R1 low word %0d", i), v, 32'h0001_0000);
      win_read(lo_idx(i) + 8'd1, v);
      check($sformatf("R1 high word %0d", i), v, 32'd0);
    end

    // R2: indirect access and undefined locations
    reg_write(5'h00, 32'h0000_005A);
    reg_read(5'h00, v);
    check("R2 index readback", v, 32'h5A);
    reg_read(5'h08, v);
    check("R2 undefined offset read", v, 32'd0);
    reg_write(5'h08, 32'h0000_0033);
    reg_read(5'h00, v);
    check("R2 undefined offset write", v, 32'h5A);
    win_write(8'h02, 32'hFFFF_FFFF);
    win_read(8'h02, v);
    check("R2 undefined index", v, 32'd0);
    win_read(lo_idx(N), v);
    check("R2 past table end", v, 32'd0);

    // R3: field layout, read-only bits, reserved bits
    win_write(lo_idx(0), 32'hFFFF_FFFF);
    win_read(lo_idx(0), v);
    check("R3 low word writable bits", v, 32'h0001_AFFF);
    win_write(lo_idx(0) + 8'd1, 32'hFFFF_FFFF);
    win_read(lo_idx(0) + 8'd1, v);
    check("R3 high word", v, 32'hFF00_0000);
    win_write(8'd0, 32'hFFFF_FFFF);
    win_read(8'd0, v);
    check("R3 id field", v, 32'h0F00_0000);
    win_write(8'd1, 32'hFFFF_FFFF);
    win_read(8'd1, v);
    check("R3 version read-only", v, {8'd0, 8'(N - 1), 8'd0, VER});
    win_write(lo_idx(0), 32'h0001_0000);

    // R5: per-line edge sweep
    for (int i = 0; i < N; i++) begin
      win_write(lo_idx(i) + 8'd1, {8'(1 << i), 24'd0});
      win_write(lo_idx(i), lo_val(8'(8'h20 + i), 3'(i), i[0], 1'b0, 1'b0, 1'b0));
      irq_in[i] = 1'b1;
      expect_msg($sformatf("R5 edge line %0d", i), 8'(8'h20 + i), 3'(i), i[0], 8'(1 << i));
      quiet($sformatf("R5 no repeat line %0d", i), 6);
      irq_in[i] = 1'b0;
      win_write(lo_idx(i), 32'h0001_0000);
    end

    // R8: all lines at once, lowest first
    for (int i = 0; i < N; i++)
      win_write(lo_idx(i), lo_val(8'(8'h30 + i), 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    irq_in = '1;
    for (int i = 0; i < N; i++)
      expect_msg($sformatf("R8 order slot %0d", i), 8'(8'h30 + i), 3'd0, 1'b0, 8'(1 << i));
    quiet("R8 nothing extra", 6);
    irq_in = '0;
    for (int i = 0; i < N; i++) win_write(lo_idx(i), 32'h0001_0000);

    // R4: active-low edge
    irq_in[3] = 1'b1;
    @(negedge clk);
    win_write(lo_idx(3), lo_val(8'h44, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0));
    quiet("R4 idle high no message", 4);
    irq_in[3] = 1'b0;
    expect_msg("R4 falling edge", 8'h44, 3'd1, 1'b1, 8'h08);
    irq_in[3] = 1'b1;
    quiet("R4 rising edge ignored", 6);
    win_write(lo_idx(3), 32'h0001_0000);
    irq_in[3] = 1'b0;

    // R9 + R10: hold under back-pressure, snapshot, delivery status
    win_write(lo_idx(0), lo_val(8'h61, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    irq_in[0] = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (msg_valid) break;
      @(negedge clk);
    end
    irq_in[0] = 1'b0;
    repeat (8) @(negedge clk);
    check("R9 valid held", {31'd0, msg_valid}, 32'd1);
    win_write(lo_idx(0), lo_val(8'h62, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R9 payload snapshot", {24'd0, msg_vector}, 32'h61);
    win_read(lo_idx(0), v);
    check("R10 status while held", v, lo_val(8'h62, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0) | 32'h1000);
    accept();
    win_read(lo_idx(0), v);
    check("R10 status after accept", v, lo_val(8'h62, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R9 valid dropped", {31'd0, msg_valid}, 32'd0);
    win_write(lo_idx(0), 32'h0001_0000);

    // R11: masked edge discarded
    irq_in[5] = 1'b1;
    @(negedge clk);
    irq_in[5] = 1'b0;
    quiet("R11 masked pulse", 4);
    win_write(lo_idx(5), lo_val(8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    quiet("R11 no delivery on unmask", 6);
    win_write(lo_idx(5), 32'h0001_0000);

    // R6: level entry with remote IRR
    win_write(lo_idx(2), lo_val(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    irq_in[2] = 1'b1;
    expect_msg("R6 level first", 8'h40, 3'd0, 1'b0, 8'h04);
    win_read(lo_idx(2), v);
    check("R6 remote IRR set", v, lo_val(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0) | 32'h4000);
    quiet("R6 held off by remote IRR", 6);
    eoi(8'h41);
    quiet("R6 other vector EOI", 6);
    eoi(8'h40);
    expect_msg("R7 re-request after EOI", 8'h40, 3'd0, 1'b0, 8'h04);
    irq_in[2] = 1'b0;
    eoi(8'h40);
    win_read(lo_idx(2), v);
    check("R7 remote IRR cleared", v, lo_val(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    quiet("R7 inactive line silent", 4);
    win_write(lo_idx(2), 32'h0001_0000);

    // R7: EOI clears every matching level entry, only those
    win_write(lo_idx(1), lo_val(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    win_write(lo_idx(4), lo_val(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    win_write(lo_idx(5), lo_val(8'h56, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    irq_in[1] = 1'b1; irq_in[4] = 1'b1; irq_in[5] = 1'b1;
    expect_msg("R8 level order line1", 8'h55, 3'd0, 1'b0, 8'h02);
    expect_msg("R8 level order line4", 8'h55, 3'd0, 1'b0, 8'h10);
    expect_msg("R8 level order line5", 8'h56, 3'd0, 1'b0, 8'h20);
    irq_in[1] = 1'b0; irq_in[4] = 1'b0; irq_in[5] = 1'b0;
    eoi(8'h55);
    win_read(lo_idx(1), v);
    check("R7 line1 cleared", {31'd0, v[14]}, 32'd0);
    win_read(lo_idx(4), v);
    check("R7 line4 cleared", {31'd0, v[14]}, 32'd0);
    win_read(lo_idx(5), v);
    check("R7 line5 kept", {31'd0, v[14]}, 32'd1);

    done = 1;
    summary();
    $finish;
  end

endmodule